// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block keeps a 16-bit up-counter that never stops. It advances by one on each terminal pulse of a 4-bit divider. The divider is itself clocked by a bus-cycle enable, so the count tracks bus cycles divided by 1, 4, 8 or 16. Neighbouring blocks, such as capture or compare logic, take the live count from a dedicated output.

Software reaches the block through a byte-wide register port with four addresses:

- **Counter high byte.** Reading it also copies the low byte into a holding buffer.
- **Counter low byte.** Reading it returns the holding buffer, so a high-then-low read pair sees one coherent 16-bit value.
- **Control register.** It holds the divider select and the overflow interrupt enable.
- **Flag register.** It holds the overflow flag.

The divider select is a one-shot setting. It is accepted only once, and only in an early window after reset. A test-mode strap lets a write to the high-byte address force the counter close to wrap-around, so overflow behaviour can be reached in a few cycles.

The register port is a plain strobed bus rather than a stream. A strobe is a single-cycle request that completes in that cycle, so there is no ready or back-pressure. Read data appears on `rdata` in the cycle after `rd_stb` and holds until the next read or reset. The count output is a continuous level.

Top module: `freerun_timer`

## Requirements
- R1: Unless a test preset is taking effect, the count increases by exactly one on each divider terminal pulse and is otherwise unchanged. While `bus_en` is low, neither the divider nor the count moves.
- R2: Control bits [1:0] select the division ratio: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. At ratio N, any run of 4·N consecutive bus cycles advances the count by exactly 4.
- R3: The first control write that arrives within the first 64 bus cycles after reset loads bits [1:0]. Any later control write, and any second write, leaves the select unchanged. Control bit 7 (interrupt enable) stays writable at all times.
- R4: A read of address 0 returns the high byte of the count as it stood in the read cycle, and captures the low byte into the buffer. A read of address 1 returns the buffer. `rdata` updates one cycle after the strobe.
- R5: Reset does not alter the low-byte holding buffer.
- R6: When `test_mode` is high, a write to address 0 sets the count to 16'hFFF8 on the next edge, whatever the data. When `test_mode` is low, such a write has no effect. A preset takes priority over a same-cycle increment.
- R7: A step of the count from 16'hFFFF to 16'h0000 sets the overflow flag, which reads as bit 7 of address 3. Writing 1 to that bit clears the flag, and writing 0 leaves it as it is. A same-cycle set wins over a clear.
- R8: `irq` is high exactly when the overflow flag and the enable (control bit 7) are both set. It stays high until software clears the flag.
- R9: Reads of any address never change the count.
- R10: After reset the count is 16'h0000, the ratio is 1, and the enable, the flag and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | One-cycle pulse per bus cycle; drives the divider and the reset window |
| test_mode | input | 1 | Enables the high-byte preset |
| addr | input | 2 | Register address: 0 count high, 1 count low, 2 control, 3 flag |
| rd_stb | input | 1 | Read request for `addr` |
| wr_stb | input | 1 | Write request for `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq | output | 1 | Overflow interrupt request |
| count_o | output | 16 | Live counter value for neighbouring blocks |

## Verification
The embedded properties check several rules on every cycle:

- the one-step advance and hold of the count;
- the preset landing on 16'hFFF8;
- the divider staying silent without `bus_en`;
- the frozen select once it is locked;
- the flag being raised on wrap;
- the capture of the low byte on a high read;
- `irq` persisting until it is cleared.

Other behaviour is visible only through the bench's scenarios:

- the exact tick rate for each ratio;
- the 64-cycle window boundary, and first-write-wins;
- coherent two-byte reads;
- the holding buffer surviving reset;
- the write-one-to-clear semantics seen through `rdata`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    DIV1  = 2'b00,
    DIV4  = 2'b01,
    DIV8  = 2'b10,
    DIV16 = 2'b11
  } div_sel_e;

  typedef enum logic [1:0] {
    A_CNT_HI = 2'd0,
    A_CNT_LO = 2'd1,
    A_CTRL   = 2'd2,
    A_FLAG   = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 7;
  localparam int FLAG_OVF_BIT = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_en,
  input  div_sel_e sel,
  output logic     tick
);
  localparam int N_SEL = 4;

  logic [PRE_W-1:0] pre_q;
  logic [N_SEL-1:0] term;

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (bus_en) pre_q <= pre_q + 1'b1;
  end

  // One terminal detector per selectable ratio: ratio 1 always, else 2^(g+1)
  for (genvar g = 0; g < N_SEL; g++) begin : g_term
    localparam int SH = (g == 0) ? 0 : g + 1;
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << SH) - 1);
    assign term[g] = &(pre_q | ~MASK);
  end

  assign tick = bus_en & term[sel];

  // R1: no bus cycle, no divider pulse
  p_idle_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> !tick);
  // R1: divider frozen without bus cycle
  p_pre_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(pre_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] PRESET_VAL = 16'hFFF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             preset,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (preset) cnt_q <= PRESET_VAL;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wrap = tick & ~preset & (&cnt_q);

  // R1: single step per tick
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !preset) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R1: hold without tick
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !preset) |=> $stable(cnt_q));
  // R6: preset lands on the fixed value
  p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> cnt_q == PRESET_VAL);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int WIN_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              test_mode,
  input  logic [1:0]        addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic [DATA_W-1:0] rdata,
  output div_sel_e          sel,
  output logic              preset,
  output logic              irq_en,
  output logic              ovf_flag
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  reg_addr_e         a;
  logic              rd_hi, rd_lo, rd_ctl, rd_flg;
  logic              wr_hi, wr_ctl, wr_flg;
  logic [WIN_W-1:0]  win_q;
  logic              win_open;
  logic              sel_done_q;
  logic              sel_locked;
  div_sel_e          sel_q;
  logic              en_q;
  logic              flag_q;
  logic [DATA_W-1:0] lo_buf_q;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_bits;

  assign a      = reg_addr_e'(addr);
  assign rd_hi  = rd_stb && a == A_CNT_HI;
  assign rd_lo  = rd_stb && a == A_CNT_LO;
  assign rd_ctl = rd_stb && a == A_CTRL;
  assign rd_flg = rd_stb && a == A_FLAG;
  assign wr_hi  = wr_stb && a == A_CNT_HI;
  assign wr_ctl = wr_stb && a == A_CTRL;
  assign wr_flg = wr_stb && a == A_FLAG;

  assign preset      = wr_hi & test_mode;
  assign unused_bits = ^wdata[6:2];

  // Bus-cycle window after reset
  assign win_open = win_q < WIN_W'(WIN_CYC);
  always_ff @(posedge clk) begin
    if (!rst_n)                 win_q <= '0;
    else if (bus_en && win_open) win_q <= win_q + 1'b1;
  end

  // One-shot divider select
  assign sel_locked = sel_done_q | ~win_open;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= DIV1;
      sel_done_q <= 1'b0;
    end else if (wr_ctl && !sel_locked) begin
      sel_q      <= div_sel_e'(wdata[1:0]);
      sel_done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_ctl) en_q <= wdata[CTRL_EN_BIT];
  end

  // Overflow flag: set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n)                              flag_q <= 1'b0;
    else if (wrap)                           flag_q <= 1'b1;
    else if (wr_flg && wdata[FLAG_OVF_BIT])  flag_q <= 1'b0;
  end

  // Low-byte holding buffer, deliberately outside reset
  always_ff @(posedge clk) begin
    if (rd_hi) lo_buf_q <= cnt[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_stb) begin
      unique case (1'b1)
        rd_hi:   rdata_q <= cnt[CNT_W-1 -: DATA_W];
        rd_lo:   rdata_q <= lo_buf_q;
        rd_ctl:  rdata_q <= {en_q, {(DATA_W-3){1'b0}}, sel_q};
        rd_flg:  rdata_q <= {flag_q, {(DATA_W-1){1'b0}}};
        default: rdata_q <= rdata_q;
      endcase
    end
  end

  assign rdata    = rdata_q;
  assign sel      = sel_q;
  assign irq_en   = en_q;
  assign ovf_flag = flag_q;

  // R3: a locked select never moves
  p_sel_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_locked |=> $stable(sel_q));
  // R7: wrap raises the flag
  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);
  // R4: high read captures the low byte
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> lo_buf_q == $past(cnt[DATA_W-1:0]));
endmodule

// File: rtl/freerun_timer.sv
module freerun_timer
  import tmr_pkg::*;
#(
  parameter int              CNT_W      = 16,
  parameter int              PRE_W      = 4,
  parameter int              WIN_CYC    = 64,
  parameter logic [CNT_W-1:0] PRESET_VAL = 16'hFFF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        test_mode,
  input  logic [1:0]  addr,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        irq,
  output logic [15:0] count_o
);
  div_sel_e         sel;
  logic             tick;
  logic             preset;
  logic             wrap;
  logic             irq_en;
  logic             ovf_flag;
  logic [CNT_W-1:0] cnt;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .sel(sel), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W), .PRESET_VAL(PRESET_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preset(preset),
    .cnt(cnt), .wrap(wrap)
  );

  tmr_regs #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .test_mode(test_mode),
    .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
    .cnt(cnt), .wrap(wrap), .rdata(rdata), .sel(sel), .preset(preset),
    .irq_en(irq_en), .ovf_flag(ovf_flag)
  );

  assign irq     = ovf_flag & irq_en;
  assign count_o = cnt;

  // R8: request persists until the flag is cleared or enable dropped
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_stb && addr == 2'd3 && wdata[7]) && !(wr_stb && addr == 2'd2))
      |=> irq);
endmodule

// File: tb/sim_freerun_timer.sv
`timescale 1ns/1ps
module sim_freerun_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b1;
  logic        test_mode = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [15:0] count_o;

  always #2.5 clk = ~clk;

  freerun_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .test_mode(test_mode),
    .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
    .rdata(rdata), .irq(irq), .count_o(count_o)
  );

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic rd_seen = 1'b0;
  logic [7:0] lo_shadow = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data is due
  always @(posedge clk) rd_seen <= rd_stb;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4 unexpected read data actual=%0h expected=none", rdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {24'd0, rdata}, {24'd0, e.v});
      end
    end
  end

  // Tasks are entered at a negedge and return at the next one
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    addr = a; rd_stb = 1'b1;
    q.push_back(x);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic rd_hi(input string tag);
    lo_shadow = count_o[7:0];
    rd(2'd0, count_o[15:8], tag);
  endtask

  task automatic rd_lo(input string tag);
    rd(2'd1, lo_shadow, tag);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rate(input int cycles, input int steps, input string tag);
    logic [15:0] v;
    v = count_o;
    repeat (cycles) @(negedge clk);
    check(tag, {16'd0, count_o}, {16'd0, 16'(v + steps)});
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();
    // R10 reset state
    check("R10 count", {16'd0, count_o}, 32'd0);
    check("R10 irq", {31'd0, irq}, 32'd0);
    v = count_o;
    rd(2'd2, 8'h00, "R10 ctrl");
    rd(2'd3, 8'h00, "R10 flag");
    // R1 ratio 1 default, R9 reads do not disturb the count
    rate(10, 10, "R1 ratio1");
    v = count_o;
    rd_hi("R4 hi");
    rd_lo("R4 lo");
    check("R9 reads keep count", {16'd0, count_o}, {16'd0, 16'(v + 2)});
    // R1 bus_en low freezes
    bus_en = 1'b0;
    rate(10, 0, "R1 frozen");
    bus_en = 1'b1;
    // R2/R3 first write inside window accepted, second ignored
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h01, "R3 first write");
    wr(2'd2, 8'h03);
    rd(2'd2, 8'h01, "R3 second write");
    rate(16, 4, "R2 ratio4");

    // R3 late write ignored
    do_reset();
    repeat (70) @(negedge clk);
    wr(2'd2, 8'h03);
    rd(2'd2, 8'h00, "R3 late write");
    rate(10, 10, "R3 late write rate");

    // R2 ratio 8 and 16
    do_reset();
    wr(2'd2, 8'h02);
    rate(32, 4, "R2 ratio8");
    do_reset();
    wr(2'd2, 8'h03);
    rate(64, 4, "R2 ratio16");

    // R6 normal mode high write no effect, then test preset
    do_reset();
    v = count_o;
    wr(2'd0, 8'h12);
    check("R6 no preset", {16'd0, count_o}, {16'd0, 16'(v + 1)});
    test_mode = 1'b1;
    wr(2'd0, 8'h00);
    check("R6 preset", {16'd0, count_o}, 32'h0000FFF8);
    rd_hi("R4 coherent hi");
    rd_lo("R4 coherent lo");
    check("R4 expected pair", {24'd0, lo_shadow}, 32'hF8);
    // R5 buffer survives reset
    do_reset();
    rd(2'd1, 8'hF8, "R5 buffer after reset");

    // R7/R8 overflow with enable
    do_reset();
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h00);
    check("R6 preset again", {16'd0, count_o}, 32'h0000FFF8);
    repeat (7) @(negedge clk);
    check("R7 at FFFF", {16'd0, count_o}, 32'h0000FFFF);
    check("R8 irq low before wrap", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R7 wrapped", {16'd0, count_o}, 32'd0);
    check("R8 irq raised", {31'd0, irq}, 32'd1);
    repeat (5) @(negedge clk);
    check("R8 irq held", {31'd0, irq}, 32'd1);
    rd(2'd3, 8'h80, "R7 flag read");
    wr(2'd3, 8'h00);
    check("R7 write zero keeps", {31'd0, irq}, 32'd1);
    wr(2'd3, 8'h80);
    check("R7 w1c clears irq", {31'd0, irq}, 32'd0);
    rd(2'd3, 8'h00, "R7 flag cleared");

    // R8 flag without enable gives no request
    do_reset();
    wr(2'd0, 8'h00);
    repeat (9) @(negedge clk);
    check("R8 no enable no irq", {31'd0, irq}, 32'd0);
    rd(2'd3, 8'h80, "R7 flag without enable");
    test_mode = 1'b0;

    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", q.size(), 32'd0);
    summary();
    $finish;
  end
endmodule